// File: doc/BRIEF.md
# Offset-Relative Payload Pattern Matcher

This block looks for short byte patterns in a packet stream that an upstream header decoder has already labelled. Each incoming byte carries a section code (which part of the packet it belongs to, such as an IPv4 or IPv6 header, an extension header, the transport header or the payload), its offset inside that section, and the tunnel depth at which the section was found. A rule names the section it cares about and compares up to `PAT_LEN` bytes against the bytes of that section. Because positions are measured from where the decoder found each section, the same rule keeps working when options or tunnels move the section around in the frame.

Each rule is either anchored or unanchored. An anchored rule only accepts a match whose first byte sits at a configured offset inside the target section. An unanchored rule accepts a match starting anywhere in the target section. A rule can require one tunnel depth or accept any depth. Each pattern byte has a bit mask, so single bits (letter case) or whole bytes can be left out of the comparison. Matches are remembered for the rest of the packet. One cycle after the last byte of the packet, the block reports a per-rule verdict together with a packet-level flag. Rules are programmed through a plain write-only register port.

Top module: `pm_offset_matcher`

## Requirements
- R1: After reset, `rule_hit`, `pkt_hit` and `pkt_done` are 0, and every rule is disabled with value and mask 0 in all pattern bytes. A packet sent before any programming gives no hit.
- R2: An anchored rule (control bit 8 = 1) matches only if pattern byte 0 falls on a byte whose section code equals the target (control bits 7:0) and whose `in_off` equals the anchor offset (register 1, bits 15:0). The following pattern bytes must fall on the bytes that come right after it.
- R3: An unanchored rule (control bit 8 = 0) accepts a match starting at any byte of the target section, and overlapping restarts are also accepted. A valid byte whose section code is not the target discards all partial progress.
- R4: If control bit 9 (any depth) is 0, only bytes whose `in_depth` equals control bits 12:10 take part in the match. If the bit is 1, any depth takes part.
- R5: A pattern byte register (register 2+k) holds the value in bits 7:0 and a care mask in bits 15:8. Data bits whose mask bit is 0 are not compared (mask 0xDF ignores letter case; mask 0x00 accepts any byte).
- R6: A match is sticky until the end of the packet. In the cycle after the valid byte that has `in_eof` = 1, `rule_hit[r]` is 1 for one cycle for each rule that matched anywhere in that packet. Matches, and partial matches, never carry over into the next packet.
- R7: `pkt_done` pulses for one cycle after every end-of-packet byte, and `pkt_hit` in that same cycle is the OR of `rule_hit`. Both are 0 in every other cycle.
- R8: Only pattern bytes 0 through len_m1 (control bits 19:16) are compared. A len_m1 value of `PAT_LEN` or more is stored as `PAT_LEN`-1.
- R9: A rule whose enable bit (control bit 13) is 0 never reports a hit.
- R10: The write address is {rule index, register index}, with the register index in the low `$clog2(PAT_LEN+2)` bits. Register 0 is the control register, register 1 the anchor offset, and registers 2 to `PAT_LEN`+1 the pattern bytes. A write takes effect on the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sect | input | 8 | Section code of the byte |
| in_off | input | 16 | Offset of the byte inside its section |
| in_depth | input | 3 | Tunnel depth of the section |
| in_eof | input | 1 | Last byte of the packet |
| cfg_we | input | 1 | Rule register write strobe |
| cfg_addr | input | $clog2(NUM_RULES)+$clog2(PAT_LEN+2) | Rule register address |
| cfg_wdata | input | 32 | Rule register write data |
| rule_hit | output | NUM_RULES | Per-rule end-of-packet hit pulse |
| pkt_hit | output | 1 | Any rule hit in the finished packet |
| pkt_done | output | 1 | End-of-packet verdict strobe |

## Verification
A table of single-section packets tries each rule at these positions: on its anchor offset, one byte before it, and with the section start shifted. It also tries each rule with case-swapped and wildcard bytes, at the right and the wrong tunnel depth, in a section that is not the target, and with a run of repeated bytes. Together these separate anchor handling, mask handling, depth filtering and the overlapping restart of the unanchored shift register. Directed packets then break a partial match with a byte from another section, split a pattern across two packets, and hold a match early in a long packet. These show that progress is discarded, that nothing crosses packet boundaries, and that the verdict stays silent until end of frame. A last test programs an oversized length, and a 7-byte run against an 8-byte run confirms the clamp.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int SECT_W  = 8;
  localparam int OFF_W   = 16;
  localparam int DEPTH_W = 3;
  localparam int LEN_W   = 4;

  typedef struct packed {
    logic               en;
    logic               anch;
    logic               any_depth;
    logic [DEPTH_W-1:0] depth;
    logic [SECT_W-1:0]  sect;
    logic [OFF_W-1:0]   aoff;
    logic [LEN_W-1:0]   len_m1;
  } rule_cfg_t;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int PAT_LEN   = 8,
  parameter int RULE_W    = $clog2(NUM_RULES),
  parameter int REG_W     = $clog2(PAT_LEN + 2)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [RULE_W+REG_W-1:0]            cfg_addr,
  input  logic [31:0]                        cfg_wdata,
  output rule_cfg_t                          cfg     [NUM_RULES],
  output logic [NUM_RULES-1:0][PAT_LEN-1:0][7:0] pat_val,
  output logic [NUM_RULES-1:0][PAT_LEN-1:0][7:0] pat_msk
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PAT_LEN - 1);

  logic [RULE_W-1:0] wr_rule;
  logic [REG_W-1:0]  wr_reg;
  logic [LEN_W-1:0]  wr_len;

  assign wr_rule = cfg_addr[RULE_W+REG_W-1:REG_W];
  assign wr_reg  = cfg_addr[REG_W-1:0];
  assign wr_len  = (cfg_wdata[19:16] > LEN_MAX) ? LEN_MAX : cfg_wdata[19:16];

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    logic hit_rule;
    assign hit_rule = cfg_we && (wr_rule == RULE_W'(r));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[r] <= '0;
      end else if (hit_rule && wr_reg == REG_W'(0)) begin
        cfg[r].sect      <= cfg_wdata[7:0];
        cfg[r].anch      <= cfg_wdata[8];
        cfg[r].any_depth <= cfg_wdata[9];
        cfg[r].depth     <= cfg_wdata[12:10];
        cfg[r].en        <= cfg_wdata[13];
        cfg[r].len_m1    <= wr_len;
      end else if (hit_rule && wr_reg == REG_W'(1)) begin
        cfg[r].aoff      <= cfg_wdata[OFF_W-1:0];
      end
    end

    for (genvar k = 0; k < PAT_LEN; k++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          pat_val[r][k] <= '0;
          pat_msk[r][k] <= '0;
        end else if (hit_rule && wr_reg == REG_W'(k + 2)) begin
          pat_val[r][k] <= cfg_wdata[7:0];
          pat_msk[r][k] <= cfg_wdata[15:8];
        end
      end
    end

    // R8: stored length never indexes past the pattern
    a_r8_len_in_range: assert property (@(posedge clk) disable iff (rst)
      cfg[r].len_m1 <= LEN_MAX);
  end
endmodule

// File: rtl/pm_rule_engine.sv
module pm_rule_engine
  import pm_pkg::*;
#(
  parameter int PAT_LEN = 8,
  parameter int IDX_W   = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic [SECT_W-1:0]        in_sect,
  input  logic [OFF_W-1:0]         in_off,
  input  logic [DEPTH_W-1:0]       in_depth,
  input  logic                     in_eof,
  input  rule_cfg_t                cfg,
  input  logic [PAT_LEN-1:0][7:0]  pat_val,
  input  logic [PAT_LEN-1:0][7:0]  pat_msk,
  output logic                     verdict
);
  logic [PAT_LEN-1:0] prog;
  logic [PAT_LEN-1:0] eq;
  logic [PAT_LEN-1:0] nxt;
  logic               sel;
  logic               start_ok;
  logic               full;
  logic               sticky;

  assign sel      = cfg.en && (in_sect == cfg.sect) &&
                    (cfg.any_depth || (in_depth == cfg.depth));
  assign start_ok = !cfg.anch || (in_off == cfg.aoff);

  always_comb begin
    for (int k = 0; k < PAT_LEN; k++)
      eq[k] = ((in_data ^ pat_val[k]) & pat_msk[k]) == 8'h00;
    nxt[0] = sel && start_ok && eq[0];
    for (int k = 1; k < PAT_LEN; k++)
      nxt[k] = sel && prog[k-1] && eq[k];
  end

  assign full    = nxt[cfg.len_m1[IDX_W-1:0]];
  assign verdict = sticky || (in_valid && full);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog   <= '0;
      sticky <= 1'b0;
    end else if (in_valid) begin
      if (in_eof) begin
        prog   <= '0;
        sticky <= 1'b0;
      end else begin
        prog <= nxt;
        if (full) sticky <= 1'b1;
      end
    end
  end

  // R3: a byte outside the target section wipes all progress
  a_r3_wipe_on_other_section: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sel) |=> (prog == '0));

  // R2: an anchored rule cannot start away from its anchor offset
  a_r2_no_start_off_anchor: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg.anch && (in_off != cfg.aoff)) |=> !prog[0]);

  // R6: nothing survives an end-of-packet byte
  a_r6_clear_at_eof: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof) |=> (!sticky && prog == '0));
endmodule

// File: rtl/pm_offset_matcher.sv
module pm_offset_matcher
  import pm_pkg::*;
#(
  parameter int NUM_RULES = 4,
  parameter int PAT_LEN   = 8,
  parameter int RULE_W    = $clog2(NUM_RULES),
  parameter int REG_W     = $clog2(PAT_LEN + 2)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  input  logic [SECT_W-1:0]       in_sect,
  input  logic [OFF_W-1:0]        in_off,
  input  logic [DEPTH_W-1:0]      in_depth,
  input  logic                    in_eof,
  input  logic                    cfg_we,
  input  logic [RULE_W+REG_W-1:0] cfg_addr,
  input  logic [31:0]             cfg_wdata,
  output logic [NUM_RULES-1:0]    rule_hit,
  output logic                    pkt_hit,
  output logic                    pkt_done
);
  rule_cfg_t                               cfg [NUM_RULES];
  logic [NUM_RULES-1:0][PAT_LEN-1:0][7:0]  pat_val;
  logic [NUM_RULES-1:0][PAT_LEN-1:0][7:0]  pat_msk;
  logic [NUM_RULES-1:0]                    verdict;

  pm_cfg_regs #(
    .NUM_RULES(NUM_RULES), .PAT_LEN(PAT_LEN), .RULE_W(RULE_W), .REG_W(REG_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg(cfg), .pat_val(pat_val), .pat_msk(pat_msk)
  );

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_eng
    pm_rule_engine #(.PAT_LEN(PAT_LEN)) u_eng (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_sect(in_sect), .in_off(in_off), .in_depth(in_depth), .in_eof(in_eof),
      .cfg(cfg[r]), .pat_val(pat_val[r]), .pat_msk(pat_msk[r]),
      .verdict(verdict[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rule_hit <= '0;
      pkt_hit  <= 1'b0;
      pkt_done <= 1'b0;
    end else begin
      pkt_done <= in_valid && in_eof;
      if (in_valid && in_eof) begin
        rule_hit <= verdict;
        pkt_hit  <= |verdict;
      end else begin
        rule_hit <= '0;
        pkt_hit  <= 1'b0;
      end
    end
  end

  // R6: a rule hit only ever follows an end-of-packet byte
  a_r6_hit_after_eof: assert property (@(posedge clk) disable iff (rst)
    (|rule_hit) |-> $past(in_valid && in_eof));

  // R7: every end-of-packet byte yields a done strobe
  a_r7_done_per_eof: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof) |=> pkt_done);

  // R7: the packet flag never appears without a done strobe
  a_r7_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    pkt_hit |-> pkt_done);
endmodule

// File: tb/test_pm_offset_matcher.sv
module test_pm_offset_matcher;
  localparam int NR = 4;
  localparam int PL = 8;
  localparam int AW = $clog2(NR) + $clog2(PL + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic [7:0]    in_sect = '0;
  logic [15:0]   in_off = '0;
  logic [2:0]    in_depth = '0;
  logic          in_eof = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NR-1:0] rule_hit;
  logic          pkt_hit;
  logic          pkt_done;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pm_offset_matcher #(.NUM_RULES(NR), .PAT_LEN(PL)) i_pm_offset_matcher (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sect(in_sect), .in_off(in_off), .in_depth(in_depth), .in_eof(in_eof),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rule_hit(rule_hit), .pkt_hit(pkt_hit), .pkt_done(pkt_done)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [7:0]  sect;
    logic [2:0]  dep;
    logic [15:0] off0;
    logic [47:0] bytes;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{"R2", 8'h06, 3'd0, 16'd0, "zzABzz", 4'b0001},
    '{"R2", 8'h06, 3'd0, 16'd0, "zABzzz", 4'b0000},
    '{"R2", 8'h06, 3'd0, 16'd1, "zABzzz", 4'b0001},
    '{"R5", 8'hFE, 3'd2, 16'd0, "qqxyzq", 4'b0010},
    '{"R5", 8'hFE, 3'd0, 16'd0, "XYZqqq", 4'b0000},
    '{"R9", 8'hFE, 3'd0, 16'd0, "qqAXyz", 4'b0010},
    '{"R4", 8'h3C, 3'd1, 16'd4, "aQ#Rbb", 4'b0100},
    '{"R4", 8'h3C, 3'd2, 16'd4, "aQ#Rbb", 4'b0000},
    '{"R3", 8'h3C, 3'd1, 16'd0, "QQQRzz", 4'b0100},
    '{"R3", 8'h06, 3'd0, 16'd9, "xyzxyz", 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int rule, input int rg, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = AW'((rule << $clog2(PL + 2)) | rg);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic put(input logic [7:0] s, input logic [2:0] dp, input logic [15:0] o,
                     input logic [7:0] d, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_sect = s; in_depth = dp; in_off = o; in_data = d; in_eof = e;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
  endtask

  task automatic verdict(input string req, input logic [3:0] exp);
    check(req, 32'(rule_hit), 32'(exp));
    check("R7", {31'd0, pkt_hit}, {31'd0, |exp});
    check("R7", {31'd0, pkt_done}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", {29'd0, rule_hit, pkt_hit, pkt_done}, 32'd0);
    put(8'hFE, 3'd0, 16'd0, "A", 1'b0);
    put(8'hFE, 3'd0, 16'd1, "A", 1'b1);
    idle();
    verdict("R1", 4'b0000);

    // R10: program rules through the register map
    wr(0, 0, 32'h06 | (1 << 8) | (1 << 9) | (1 << 13) | (1 << 16));
    wr(0, 1, 32'd2);
    wr(0, 2, 32'hFF00 | "A");
    wr(0, 3, 32'hFF00 | "B");
    wr(0, 4, 32'hFF00 | "Q");            // beyond length: R8
    wr(1, 0, 32'hFE | (1 << 9) | (1 << 13) | (2 << 16));
    wr(1, 2, 32'hDF00 | "X");
    wr(1, 3, 32'hFF00 | "y");
    wr(1, 4, 32'hFF00 | "z");
    wr(2, 0, 32'h3C | (1 << 10) | (1 << 13) | (2 << 16));
    wr(2, 2, 32'hFF00 | "Q");
    wr(2, 3, 32'h0000);
    wr(2, 4, 32'hFF00 | "R");
    wr(3, 0, 32'hFE | (1 << 9));          // disabled: R9
    wr(3, 2, 32'hFF00 | "A");

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 6; i++)
        put(VECS[v].sect, VECS[v].dep, VECS[v].off0 + 16'(i),
            VECS[v].bytes[47-8*i -: 8], i == 5);
      idle();
      verdict(string'(VECS[v].tag), VECS[v].exp);
    end

    // R3: a foreign-section byte breaks a partial match
    put(8'hFE, 3'd0, 16'd0, "x", 1'b0);
    put(8'hFE, 3'd0, 16'd1, "y", 1'b0);
    put(8'h06, 3'd0, 16'd0, "z", 1'b0);
    put(8'hFE, 3'd0, 16'd2, "z", 1'b1);
    idle();
    verdict("R3", 4'b0000);

    // R6: a pattern split across two packets does not match
    put(8'hFE, 3'd0, 16'd0, "x", 1'b0);
    put(8'hFE, 3'd0, 16'd1, "y", 1'b1);
    put(8'hFE, 3'd0, 16'd0, "z", 1'b1);
    idle();
    verdict("R6", 4'b0000);

    // R6: early match held silently until end of frame, then one pulse
    put(8'hFE, 3'd0, 16'd0, "x", 1'b0);
    put(8'hFE, 3'd0, 16'd1, "y", 1'b0);
    put(8'hFE, 3'd0, 16'd2, "z", 1'b0);
    for (int i = 3; i < 7; i++) begin
      put(8'hFE, 3'd0, 16'(i), "q", 1'b0);
      check("R6", {28'd0, rule_hit}, 32'd0);
    end
    put(8'hFE, 3'd0, 16'd7, "q", 1'b1);
    idle();
    verdict("R6", 4'b0010);
    @(negedge clk);
    check("R6", {29'd0, rule_hit, pkt_hit, pkt_done}, 32'd0);

    // R8: oversized length is clamped to the full pattern
    wr(3, 0, 32'h11 | (1 << 9) | (1 << 13) | (15 << 16));
    for (int i = 0; i < 7; i++) put(8'h11, 3'd0, 16'(i), "A", i == 6);
    idle();
    verdict("R8", 4'b0000);
    for (int i = 0; i < 8; i++) put(8'h11, 3'd0, 16'(i), "A", i == 7);
    idle();
    verdict("R8", 4'b1000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule